// File: doc/BRIEF.md
# Multi-Rail Reset Supervisor

This block produces a system reset for a design that is powered from several supply rails. External comparators report, one flag per rail, whether that rail is above its threshold. The block also takes an active-low push-button style manual reset. It drives a reset of each polarity. The two outputs always disagree.

Any missing rail or a pressed manual reset forces reset active within a few clock cycles. Release is held back until every rail flag and the manual reset have stayed good, without a break, for a programmable number of cycles of a free-running clock. Any fault inside that window throws away the time already counted. All status inputs are asynchronous to the clock and are resynchronized inside the block.

Top module: `rail_rst_supervisor`

## Requirements
- R1: When any one rail flag (rail_ok_i bit, 1 = good) is low, reset goes active (rst_o = 1), whatever the other flags show.
- R2: A low level on man_rst_n_i forces reset active, whatever the rail flags show.
- R3: Reset releases only while every rail flag is high and man_rst_n_i is high, as seen after synchronization.
- R4: After all inputs become good, reset releases on the SYNC_STAGES+HOLD_CYCLES-th rising clock edge, and not before.
- R5: A fault that appears during the hold-off window clears the count, and a full HOLD_CYCLES window is needed again once the inputs are good.
- R6: A fault that spans at least one rising edge sets reset active on the SYNC_STAGES+1-th rising edge after the input changes.
- R7: rst_n_o is always the complement of rst_o.
- R8: While arst_n is low, rst_o = 1 and rst_n_o = 0, and the hold-off count is cleared.
- R9: Once released, reset stays inactive for as long as all inputs stay good.
- R10: Release after a manual reset uses the same hold-off delay as release after a rail fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock that times the hold-off |
| arst_n | input | 1 | Asynchronous reset of the block itself, active low |
| rail_ok_i | input | NUM_RAILS | One flag per rail from the comparators, 1 = above threshold, asynchronous |
| man_rst_n_i | input | 1 | Manual reset request, active low, asynchronous |
| rst_o | output | 1 | System reset, active high |
| rst_n_o | output | 1 | System reset, active low |

## Verification
Each input takes SYNC_STAGES edges to reach the logic, and the output stage adds one more edge. A fault therefore shows at the outputs on edge SYNC_STAGES+1 after the input changes. Release shows on edge SYNC_STAGES+HOLD_CYCLES after the last input turns good. The bench changes inputs on the falling clock edge and counts rising edges from that point. It samples one nanosecond after the edge where a change is due and also one edge earlier, so a design that is early or late by one cycle fails the check. The checker does the same for the hold-off window with a run counter of good cycles and does not rely on a deep $past.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

   // Width of a counter that has to hold values 0 .. n-1.
   function automatic int unsigned rrs_cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   // Supervisor output state.
   typedef enum logic {
      SUP_RELEASED = 1'b0,
      SUP_HELD     = 1'b1
   } sup_state_e;

endpackage

// File: rtl/rrs_sync.sv
// Multi-bit, multi-stage synchronizer. Each bit gets its own flop chain.
module rrs_sync #(
   parameter int unsigned WIDTH   = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   initial begin
      assert (STAGES >= 2) else $error("rrs_sync: STAGES must be at least 2");
      assert (WIDTH >= 1)  else $error("rrs_sync: WIDTH must be at least 1");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) chain_q <= {STAGES{RST_VAL}};
         else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = chain_q[STAGES-1];
   end

endmodule

// File: rtl/rrs_fault_merge.sv
// Merges synchronized rail flags and the manual request into one fault line.
module rrs_fault_merge #(
   parameter int unsigned NUM_RAILS = 3
) (
   input  logic [NUM_RAILS-1:0] rail_ok_s,
   input  logic                 man_rst_n_s,
   output logic                 fault_o
);

   logic all_rails_ok;

   assign all_rails_ok = &rail_ok_s;
   assign fault_o      = !all_rails_ok || !man_rst_n_s;

endmodule

// File: rtl/rrs_holdoff.sv
// Hold-off timer and next-state logic for the reset output.
module rrs_holdoff
   import rrs_pkg::*;
#(
   parameter int unsigned HOLD_CYCLES = 8
) (
   input  logic       clk,
   input  logic       arst_n,
   input  logic       fault_i,
   input  sup_state_e state_q,
   output sup_state_e state_d
);

   localparam int unsigned CNT_W = rrs_cnt_w(HOLD_CYCLES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

   initial begin
      assert (HOLD_CYCLES >= 1) else $error("rrs_holdoff: HOLD_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      if (fault_i) begin
         state_d = SUP_HELD;
         cnt_d   = '0;
      end else if (state_q == SUP_HELD) begin
         if (cnt_q == CNT_LAST) begin
            state_d = SUP_RELEASED;
            cnt_d   = '0;
         end else begin
            cnt_d = cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) cnt_q <= '0;
      else         cnt_q <= cnt_d;
   end

endmodule

// File: rtl/rrs_out_drive.sv
// Registers the reset state into two independent flops, one per polarity.
module rrs_out_drive
   import rrs_pkg::*;
(
   input  logic       clk,
   input  logic       arst_n,
   input  sup_state_e state_d,
   output sup_state_e state_q,
   output logic       rst_o,
   output logic       rst_n_o
);

   logic hi_q, lo_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         hi_q <= 1'b1;
         lo_q <= 1'b0;
      end else begin
         hi_q <= (state_d == SUP_HELD);
         lo_q <= (state_d != SUP_HELD);
      end
   end

   assign state_q = hi_q ? SUP_HELD : SUP_RELEASED;
   assign rst_o   = hi_q;
   assign rst_n_o = lo_q;

endmodule

// File: rtl/rail_rst_supervisor.sv
module rail_rst_supervisor
   import rrs_pkg::*;
#(
   parameter int unsigned NUM_RAILS   = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD_CYCLES = 20_000_000
) (
   input  logic                 clk,
   input  logic                 arst_n,
   input  logic [NUM_RAILS-1:0] rail_ok_i,
   input  logic                 man_rst_n_i,
   output logic                 rst_o,
   output logic                 rst_n_o
);

   localparam int unsigned IN_W = NUM_RAILS + 1;

   initial begin
      assert (NUM_RAILS >= 1) else $error("rail_rst_supervisor: NUM_RAILS must be at least 1");
   end

   logic [IN_W-1:0]      raw_in, sync_in;
   logic [NUM_RAILS-1:0] rail_ok_s;
   logic                 man_rst_n_s;
   logic                 fault_s;
   sup_state_e           state_q, state_d;

   assign raw_in = {man_rst_n_i, rail_ok_i};

   // Reset value 0 reads as "not good", so a fresh block starts in reset.
   rrs_sync #(
      .WIDTH  (IN_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b0)
   ) u_sync (
      .clk   (clk),
      .arst_n(arst_n),
      .d_i   (raw_in),
      .q_o   (sync_in)
   );

   assign rail_ok_s   = sync_in[NUM_RAILS-1:0];
   assign man_rst_n_s = sync_in[NUM_RAILS];

   rrs_fault_merge #(.NUM_RAILS(NUM_RAILS)) u_merge (
      .rail_ok_s  (rail_ok_s),
      .man_rst_n_s(man_rst_n_s),
      .fault_o    (fault_s)
   );

   rrs_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
      .clk    (clk),
      .arst_n (arst_n),
      .fault_i(fault_s),
      .state_q(state_q),
      .state_d(state_d)
   );

   rrs_out_drive u_out (
      .clk    (clk),
      .arst_n (arst_n),
      .state_d(state_d),
      .state_q(state_q),
      .rst_o  (rst_o),
      .rst_n_o(rst_n_o)
   );

endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
   parameter int unsigned HOLD_CYCLES = 8
) (
   input logic clk,
   input logic arst_n,
   input logic fault_s,
   input logic rst_o,
   input logic rst_n_o
);

   localparam int unsigned RUN_W = $clog2(HOLD_CYCLES + 1) + 1;
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(HOLD_CYCLES);

   // Consecutive cycles with no fault, saturating at HOLD_CYCLES.
   logic [RUN_W-1:0] good_run;
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)               good_run <= '0;
      else if (fault_s)          good_run <= '0;
      else if (good_run != RUN_MAX) good_run <= good_run + 1'b1;
   end

   a_r7_complement: assert property (@(posedge clk) disable iff (!arst_n)
      rst_o != rst_n_o);

   a_r6_fault_asserts: assert property (@(posedge clk) disable iff (!arst_n)
      fault_s |=> rst_o);

   a_r3_release_needs_good: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(rst_o) |-> $past(!fault_s));

   a_r4_full_holdoff: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(rst_o) |-> (good_run == RUN_MAX));

   a_r9_stays_released: assert property (@(posedge clk) disable iff (!arst_n)
      (!rst_o && !fault_s) |=> !rst_o);

endmodule

bind rail_rst_supervisor rrs_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
   .clk    (clk),
   .arst_n (arst_n),
   .fault_s(fault_s),
   .rst_o  (rst_o),
   .rst_n_o(rst_n_o)
);

// File: tb/rail_rst_supervisor_tb_top.sv
`timescale 1ns/1ps
module rail_rst_supervisor_tb_top;

   localparam int unsigned NR   = 3;
   localparam int unsigned SS   = 2;
   localparam int unsigned HOLD = 8;

   logic          clk = 1'b0;
   logic          arst_n = 1'b0;
   logic [NR-1:0] rails = '0;
   logic          mr_n = 1'b0;
   logic          rst_o, rst_n_o;
   int            checks = 0;
   int            errors = 0;
   bit            done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   rail_rst_supervisor #(
      .NUM_RAILS  (NR),
      .SYNC_STAGES(SS),
      .HOLD_CYCLES(HOLD)
   ) dut_i (
      .clk        (clk),
      .arst_n     (arst_n),
      .rail_ok_i  (rails),
      .man_rst_n_i(mr_n),
      .rst_o      (rst_o),
      .rst_n_o    (rst_n_o)
   );

   typedef struct packed {
      logic [2:0] rails;
      logic       mr_n;
      logic [7:0] wait_edges;
      logic       exp_rst;
   } vec_t;

   // Each row: apply inputs on a falling edge, wait rising edges, expect rst_o.
   localparam vec_t TBL [0:13] = '{
      '{3'b111, 1'b1, 8'd9,  1'b1},  // R4: one edge before release
      '{3'b111, 1'b1, 8'd1,  1'b0},  // R4: released on edge SS+HOLD
      '{3'b110, 1'b1, 8'd2,  1'b0},  // R6: not yet asserted
      '{3'b110, 1'b1, 8'd1,  1'b1},  // R1 R6: asserted on edge SS+1
      '{3'b111, 1'b0, 8'd20, 1'b1},  // R2 R3: manual reset holds
      '{3'b111, 1'b1, 8'd9,  1'b1},  // R10: hold-off after manual reset
      '{3'b111, 1'b1, 8'd1,  1'b0},  // R10: release on edge SS+HOLD
      '{3'b101, 1'b1, 8'd3,  1'b1},  // R1: middle rail
      '{3'b011, 1'b1, 8'd3,  1'b1},  // R1: top rail
      '{3'b111, 1'b1, 8'd5,  1'b1},  // R5: part of window counted
      '{3'b110, 1'b1, 8'd3,  1'b1},  // R5: fault inside window
      '{3'b111, 1'b1, 8'd9,  1'b1},  // R5: full window needed again
      '{3'b111, 1'b1, 8'd1,  1'b0},  // R5: released
      '{3'b111, 1'b1, 8'd50, 1'b0}   // R9: stays released
   };

   task automatic check(input string req, input logic exp);
      checks++;
      if (rst_o !== exp || rst_n_o !== ~exp) begin
         errors++;
         $display("FAIL %s: rst_o=%b rst_n_o=%b expected rst_o=%b rst_n_o=%b",
                  req, rst_o, rst_n_o, exp, ~exp);
      end
   endtask

   task automatic wait_edges(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      // R8: state while the block's own reset is held
      repeat (3) @(posedge clk);
      #1;
      check("R8 reset state", 1'b1);
      @(negedge clk);
      arst_n = 1'b1;

      for (int v = 0; v < 14; v++) begin
         @(negedge clk);
         rails = TBL[v].rails;
         mr_n  = TBL[v].mr_n;
         wait_edges(int'(TBL[v].wait_edges));
         check($sformatf("R1..R10 table row %0d", v), TBL[v].exp_rst);
      end

      // R8: asynchronous reset while released forces reset at once
      @(negedge clk);
      arst_n = 1'b0;
      #1;
      check("R8 async assert", 1'b1);
      @(negedge clk);
      arst_n = 1'b1;
      wait_edges(SS + HOLD - 1);
      check("R8 count cleared, R4 still held", 1'b1);
      wait_edges(1);
      check("R8 R4 release after reset", 1'b0);

      // R6 R5: one-cycle glitch on a rail still produces a full reset pulse
      @(negedge clk);
      rails = 3'b110;
      @(negedge clk);
      rails = 3'b111;
      wait_edges(SS - 1);   // SS edges since the glitch began
      check("R6 glitch not yet seen", 1'b0);
      wait_edges(1);
      check("R6 glitch asserts", 1'b1);
      wait_edges(SS + HOLD - 3);
      check("R5 glitch hold-off running", 1'b1);
      wait_edges(1);
      check("R5 glitch hold-off done", 1'b0);

      // R2: manual reset with all rails good, then rails fail while held (R3)
      @(negedge clk);
      mr_n = 1'b0;
      wait_edges(SS + 1);
      check("R2 manual asserts", 1'b1);
      @(negedge clk);
      mr_n  = 1'b1;
      rails = 3'b000;
      wait_edges(SS + HOLD + 4);
      check("R3 no release with rails down", 1'b1);

      finish_run();
   end

endmodule